// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral and Jam Controller

This block decides when a half-duplex 10 Mb/s Ethernet transmitter may start a frame or start it again. It also produces the jam sequence that follows a collision. A deferral timer runs on a bit-time enable. It counts the quiet time on the medium after carrier sense drops, and it opens the transmit window only after a full interframe gap.

If carrier comes back early in the gap, the timer starts over. If carrier comes back late in the gap, the timer ignores it and runs to the end.

A collision during a frame starts a burst of all-ones jam bits. If the collision lands inside the preamble, the burst waits until the preamble has ended. When the jam is complete, the block does three things:

- It sends a one-cycle pulse to the backoff logic.
- It keeps the transmitter silent until that logic reports that backoff is complete.
- It then makes the transmitter defer again before any retry.

Top module: `tx_defer_jam`

## Requirements
- R1: After reset `tx_permit`, `jam_active`, `jam_bit` and `col_done` are 0, and the deferral count starts from zero.
- R2: With `bit_en` high every cycle and `crs` low, `tx_permit` (with `tx_req` high) first reads 1 after the 96th clock edge counted from the start of the quiet period.
- R3: If `crs` goes high again when fewer than 64 quiet bit times have been counted, the count is cleared. A full 96 quiet bit times after the next carrier drop are then needed.
- R4: If `crs` goes high again when 64 or more quiet bit times have been counted, it is ignored. The gap still completes 96 bit times after the first drop.
- R5: Once a frame is granted, `tx_permit` stays 1 regardless of `crs` until `tx_req` falls. A new grant then needs a fresh 96-bit quiet gap.
- R6: A collision (`col` high) while a frame is being sent and `preamble_on` is low makes `jam_active` read 1 after that clock edge. It stays 1 for exactly 32 `bit_en` pulses. `jam_bit` is 1 whenever `jam_active` is 1 and 0 otherwise.
- R7: A collision while `preamble_on` is high holds off the jam while the preamble lasts. The full 32-bit jam starts on the edge where `preamble_on` is seen low.
- R8: On the edge that ends the jam, `col_done` reads 1 for exactly one cycle. `tx_permit` stays 0 from the collision until `backoff_done` is seen.
- R9: After `backoff_done`, transmission still waits for `crs` to be low for a full 96 bit times.
- R10: `col` asserted while no frame is being sent has no effect: no jam, no `col_done`, and the deferral count keeps running.
- R11: Clock edges with `bit_en` low advance neither the deferral count nor the jam count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle pulse per 10 Mb/s bit time |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision detect |
| tx_req | input | 1 | Frame pending; held high until the frame ends |
| preamble_on | input | 1 | Serializer is sending preamble |
| backoff_done | input | 1 | Backoff delay has elapsed |
| tx_permit | output | 1 | Transmitter may start or continue a frame |
| jam_active | output | 1 | Jam burst in progress |
| jam_bit | output | 1 | Jam data bit |
| col_done | output | 1 | One-cycle pulse when the jam is complete |

## Verification
The corners that are hardest to reach are the 63/64 boundary of the qualifying interval and a collision whose jam must wait for a preamble of arbitrary length. The bench sweeps the cycle at which carrier reasserts across every quiet length from 1 to 91 bit times and compares the grant cycle with an arithmetic expectation. It also sweeps preamble hold-off length against several `bit_en` spacings, counting the enables seen during each jam.

// File: rtl/txdj_pkg.sv
package txdj_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_HOLD,
        ST_JAM,
        ST_BACKOFF
    } tx_state_e;

endpackage

// File: rtl/txdj_defer_timer.sv
module txdj_defer_timer #(
    parameter int GAP_BITS  = 96,
    parameter int QUAL_BITS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic crs,
    output logic gap_ok
);
    localparam int CW = $clog2(GAP_BITS + 1);
    localparam logic [CW-1:0] GAP_C  = CW'(GAP_BITS);
    localparam logic [CW-1:0] QUAL_C = CW'(QUAL_BITS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } defer_reg_t;

    defer_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (bit_en) begin
            if (r_q.cnt == GAP_C) begin
                if (crs) r_d.cnt = '0;
            end else if (crs && (r_q.cnt < QUAL_C)) begin
                r_d.cnt = '0;
            end else begin
                r_d.cnt = r_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign gap_ok = (r_q.cnt == GAP_C);

    a_r2_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= GAP_C);

    a_r3_early_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && crs && r_q.cnt < QUAL_C) |=> (r_q.cnt == '0));

    a_r4_late_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && crs && r_q.cnt >= QUAL_C && r_q.cnt < GAP_C)
        |=> (r_q.cnt == $past(r_q.cnt) + CW'(1)));

    a_r11_defer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(r_q.cnt));

endmodule

// File: rtl/txdj_jam_counter.sv
module txdj_jam_counter #(
    parameter int JAM_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic run,
    output logic jam_bit,
    output logic done
);
    localparam int JW = (JAM_BITS > 1) ? $clog2(JAM_BITS) : 1;
    localparam logic [JW-1:0] LAST_C = JW'(JAM_BITS - 1);

    typedef struct packed {
        logic [JW-1:0] cnt;
    } jam_reg_t;

    jam_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!run) begin
            r_d.cnt = '0;
        end else if (bit_en) begin
            r_d.cnt = (r_q.cnt == LAST_C) ? '0 : r_q.cnt + JW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done    = run && bit_en && (r_q.cnt == LAST_C);
    assign jam_bit = run;

    a_r6_jam_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= LAST_C);

    a_r11_jam_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bit_en) |=> (r_q.cnt == $past(r_q.cnt)));

endmodule

// File: rtl/txdj_ctrl.sv
module txdj_ctrl
    import txdj_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_req,
    input  logic gap_ok,
    input  logic col,
    input  logic preamble_on,
    input  logic jam_done,
    input  logic backoff_done,
    output logic tx_permit,
    output logic jam_run,
    output logic col_done
);
    typedef struct packed {
        tx_state_e st;
        logic      done_pulse;
    } ctrl_reg_t;

    ctrl_reg_t r_d, r_q;

    always_comb begin
        r_d            = r_q;
        r_d.done_pulse = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (tx_req && gap_ok) r_d.st = ST_SEND;
            end
            ST_SEND: begin
                if (col)          r_d.st = preamble_on ? ST_HOLD : ST_JAM;
                else if (!tx_req) r_d.st = ST_IDLE;
            end
            ST_HOLD: begin
                if (!preamble_on) r_d.st = ST_JAM;
            end
            ST_JAM: begin
                if (jam_done) begin
                    r_d.st         = ST_BACKOFF;
                    r_d.done_pulse = 1'b1;
                end
            end
            ST_BACKOFF: begin
                if (backoff_done) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st         <= ST_IDLE;
            r_q.done_pulse <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_permit = (r_q.st == ST_SEND) ||
                       ((r_q.st == ST_IDLE) && tx_req && gap_ok);
    assign jam_run   = (r_q.st == ST_JAM);
    assign col_done  = r_q.done_pulse;

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        col_done |=> !col_done);

    a_r8_silent_backoff: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BACKOFF && !backoff_done) |=> !tx_permit);

    a_r7_hold_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HOLD && preamble_on) |=> !jam_run);

    a_r10_idle_col: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && col) |=> !jam_run);

endmodule

// File: rtl/tx_defer_jam.sv
module tx_defer_jam #(
    parameter int GAP_BITS  = 96,
    parameter int QUAL_BITS = 64,
    parameter int JAM_BITS  = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic crs,
    input  logic col,
    input  logic tx_req,
    input  logic preamble_on,
    input  logic backoff_done,
    output logic tx_permit,
    output logic jam_active,
    output logic jam_bit,
    output logic col_done
);
    logic gap_ok;
    logic jam_run;
    logic jam_done;

    txdj_defer_timer #(
        .GAP_BITS (GAP_BITS),
        .QUAL_BITS(QUAL_BITS)
    ) i_defer (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_en(bit_en),
        .crs   (crs),
        .gap_ok(gap_ok)
    );

    txdj_jam_counter #(
        .JAM_BITS(JAM_BITS)
    ) i_jam (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .run    (jam_run),
        .jam_bit(jam_bit),
        .done   (jam_done)
    );

    txdj_ctrl i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_req      (tx_req),
        .gap_ok      (gap_ok),
        .col         (col),
        .preamble_on (preamble_on),
        .jam_done    (jam_done),
        .backoff_done(backoff_done),
        .tx_permit   (tx_permit),
        .jam_run     (jam_run),
        .col_done    (col_done)
    );

    assign jam_active = jam_run;

    a_r6_jam_excludes_permit: assert property (@(posedge clk) disable iff (!rst_n)
        jam_bit |-> !tx_permit);

    a_r8_done_after_jam: assert property (@(posedge clk) disable iff (!rst_n)
        col_done |-> ($past(jam_active) && !jam_active));

endmodule

// File: tb/test_tx_defer_jam.sv
module test_tx_defer_jam;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0, crs = 1'b1, col = 1'b0, tx_req = 1'b0;
    logic preamble_on = 1'b0, backoff_done = 1'b0;
    logic tx_permit, jam_active, jam_bit, col_done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit timed_out = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tx_defer_jam i_tx_defer_jam (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .crs(crs), .col(col),
        .tx_req(tx_req), .preamble_on(preamble_on), .backoff_done(backoff_done),
        .tx_permit(tx_permit), .jam_active(jam_active), .jam_bit(jam_bit),
        .col_done(col_done)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; crs = 1'b1; col = 1'b0; tx_req = 1'b0; bit_en = 1'b1;
        preamble_on = 1'b0; backoff_done = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
    endtask

    // edges until tx_permit with crs low and bit_en every edge
    task automatic wait_grant(output int first);
        first = 0;
        for (int e = 1; e <= 400 && first == 0; e++) begin
            tick();
            if (tx_permit) first = e;
        end
    endtask

    task automatic run_all();
        int first, expv;
        // R1 reset state
        do_reset();
        tx_req = 1'b1;
        #1;
        chk(!tx_permit && !jam_active && !jam_bit && !col_done, "R1",
            {tx_permit, jam_active, jam_bit, col_done}, 0);

        // R2/R3/R4 sweep of the carrier re-assert point
        for (int k = 1; k <= 91; k++) begin
            do_reset();
            tx_req = 1'b1;
            first = 0;
            for (int e = 1; e <= 400 && first == 0; e++) begin
                crs = (e > k) && (e <= k + 4);
                tick();
                if (tx_permit) first = e;
            end
            expv = (k < 64) ? k + 4 + 96 : 96;
            chk(first == expv, (k < 64) ? "R3" : "R4", first, expv);
        end

        // R2 plain gap, R11 sparse bit_en
        for (int p = 1; p <= 4; p++) begin
            do_reset();
            tx_req = 1'b1; crs = 1'b0;
            first = 0;
            for (int e = 1; e <= 500 && first == 0; e++) begin
                bit_en = (e % p) == 0;
                tick();
                if (tx_permit) first = e;
            end
            chk(first == 96 * p, (p == 1) ? "R2" : "R11", first, 96 * p);
        end

        // R5 grant held under own carrier, then fresh gap
        do_reset();
        tx_req = 1'b1; crs = 1'b0;
        wait_grant(first);
        tick();
        crs = 1'b1;
        begin
            int drops = 0;
            for (int i = 0; i < 50; i++) begin
                tick();
                if (!tx_permit) drops++;
            end
            chk(drops == 0, "R5", drops, 0);
        end
        tx_req = 1'b0;
        tick();
        tx_req = 1'b1; crs = 1'b0;
        #1;
        chk(!tx_permit, "R5", tx_permit, 0);
        wait_grant(first);
        chk(first == 96, "R5", first, 96);

        // R10 collision with nothing being sent
        do_reset();
        crs = 1'b0; col = 1'b1;
        begin
            int bad = 0;
            for (int i = 0; i < 100; i++) begin
                tick();
                if (jam_active || col_done || jam_bit) bad++;
            end
            chk(bad == 0, "R10", bad, 0);
        end
        col = 1'b0; tx_req = 1'b1;
        #1;
        chk(tx_permit, "R10", tx_permit, 1);

        // R6/R7/R8/R9 collision sweep: preamble hold-off x bit_en spacing
        for (int pre = 0; pre <= 6; pre++) begin
            for (int per = 1; per <= 3; per++) begin
                int nbe, bad, quiet, ph;
                do_reset();
                tx_req = 1'b1; crs = 1'b0;
                wait_grant(first);
                tick();                       // now sending
                crs = 1'b1; col = 1'b1; preamble_on = (pre > 0);
                tick();
                col = 1'b0;
                if (pre > 0) begin
                    bad = jam_active ? 1 : 0;
                    for (int i = 1; i < pre; i++) begin
                        tick();
                        if (jam_active) bad++;
                    end
                    chk(bad == 0, "R7", bad, 0);
                    preamble_on = 1'b0;
                    tick();
                end
                chk(jam_active && jam_bit && !tx_permit, (pre > 0) ? "R7" : "R6",
                    {jam_active, jam_bit, tx_permit}, 6);
                nbe = 0; bad = 0; ph = 0;
                while (jam_active && nbe < 100) begin
                    ph++;
                    bit_en = (ph % per) == 0;
                    tick();
                    if (bit_en) nbe++;
                    if (jam_active && (!jam_bit || tx_permit)) bad++;
                end
                bit_en = 1'b1;
                chk(nbe == 32 && bad == 0, "R6", nbe, 32);
                chk(col_done && !jam_bit && !tx_permit, "R8",
                    {col_done, jam_bit, tx_permit}, 4);
                tick();
                chk(!col_done, "R8", col_done, 0);
                crs = 1'b0;
                quiet = 0;
                for (int i = 0; i < 120; i++) begin
                    tick();
                    if (tx_permit || col_done) quiet++;
                end
                chk(quiet == 0, "R8", quiet, 0);
                crs = 1'b1; backoff_done = 1'b1;
                tick();
                backoff_done = 1'b0;
                tick();
                chk(!tx_permit, "R9", tx_permit, 0);
                crs = 1'b0;
                wait_grant(first);
                chk(first == 96, "R9", first, 96);
            end
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                wait (cyc >= 190000);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule